// File: doc/BRIEF.md
# Triggered Arbitrary Waveform Player

The player keeps a table of 14-bit sample codes in an on-chip memory and, once a trigger arrives, presents them one after another on a parallel bus that feeds a DAC. A host fills the table through a write port. First it strobes a base address. Then it pushes samples, which land at consecutive addresses. The number of samples pushed since the last base strobe becomes the waveform length. Each sample is held for a programmable number of clock cycles. With a 100 MHz clock, the step rate is 100 MHz divided by that count.

In one-shot mode a trigger plays the table once and the player then returns to idle. In loop mode the table repeats from its first sample until a clear is given. While idle, the bus carries the code stored at address 0. A complemented copy of the bus is always available for the inverted DAC output. A busy flag is high during playback.

Top module: `wave_player`

## Requirements
- R1: A `ld_set` strobe sets the write pointer to `ld_addr` and the length to zero. Each `wr_en` cycle without `ld_set` writes `wr_data` at the pointer and advances the pointer by one. On the same edge, `ld_set` takes priority and that cycle's write is dropped.
- R2: Each sample stays on `dac_out` for exactly D clock cycles. D is the `divider` value captured at the trigger, and a captured value of 0 acts as 1.
- R3: A trigger is accepted when `trig` is high at a rising edge, the player is idle, the length is non-zero and `clear` is low. On that edge `busy` rises. The first sample (at the base address) appears on `dac_out` after the next edge.
- R4: In one-shot mode (`loop_mode`=0 at the trigger), with length L, `busy` stays high for exactly L*D cycles. After the last sample's D cycles, `dac_out` returns to the address-0 code.
- R5: In loop mode (`loop_mode`=1 at the trigger), the sample after the last one is the first one again, with no gap, and `busy` stays high.
- R6: While idle, `dac_out` shows the code stored at address 0, one cycle behind the memory content.
- R7: A trigger that arrives while playback runs has no effect on the sample sequence or on `busy`.
- R8: `clear` high at an edge ends playback on that edge. `busy` drops, and `dac_out` shows the address-0 code one cycle later.
- R9: `dac_out_n` is the bitwise complement of `dac_out` in every cycle.
- R10: A trigger while the length is zero is ignored, and `busy` stays low.
- R11: Write and playback addresses wrap modulo the memory depth. The length saturates at the depth, so a table of full depth plays every entry starting from the base.
- R12: After reset, `busy` is low and the length is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_set | input | 1 | Strobe: set base/write pointer, zero length |
| ld_addr | input | ADDR_W | Base address for a new table |
| wr_en | input | 1 | Write one sample at the pointer |
| wr_data | input | SAMPLE_W | Sample code to write |
| divider | input | DIV_W | Clock cycles per sample step (0 acts as 1) |
| loop_mode | input | 1 | 1 = repeat continuously, 0 = play once |
| trig | input | 1 | Start request |
| clear | input | 1 | Abort playback |
| dac_out | output | SAMPLE_W | Straight sample code |
| dac_out_n | output | SAMPLE_W | Complemented sample code |
| busy | output | 1 | Playback running |

## Verification
A small configuration (16 entries, 4-bit divider) is swept over every length from 1 to 5 and every divider value from 0 to 4 in one-shot mode. This separates a wrong hold count from a wrong address step or an early or late end of `busy`. Loop runs over several periods show whether the wrap goes back to the base or to address 0. Triggers during a run, clears in mid-run, triggers with an empty table and an over-full table that wraps across address 0 each exercise a different priority or boundary of the sequencer.

// File: rtl/wp_pkg.sv
package wp_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } play_state_e;

  typedef enum logic {
    MODE_ONCE = 1'b0,
    MODE_LOOP = 1'b1
  } play_mode_e;

endpackage

// File: rtl/wp_sample_ram.sv
module wp_sample_ram #(
  parameter int SAMPLE_W = 14,
  parameter int DEPTH    = 1024,
  localparam int ADDR_W  = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                we,
  input  logic [ADDR_W-1:0]   waddr,
  input  logic [SAMPLE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]   raddr,
  output logic [SAMPLE_W-1:0] rdata
);

  logic [SAMPLE_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    rdata <= mem_q[raddr];
  end

endmodule

// File: rtl/wp_loader.sv
module wp_loader #(
  parameter int DEPTH   = 1024,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_set,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              wr_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [ADDR_W-1:0] base,
  output logic [CNT_W-1:0]  len
);

  localparam logic [CNT_W-1:0] LEN_MAX = CNT_W'(DEPTH);

  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              ptr_en;

  assign mem_we    = wr_en & ~ld_set;
  assign mem_waddr = ptr_q;
  assign base      = base_q;
  assign len       = cnt_q;
  assign ptr_en    = ld_set | wr_en;

  always_comb begin
    ptr_d  = ptr_q;
    base_d = base_q;
    cnt_d  = cnt_q;
    if (ld_set) begin
      ptr_d  = ld_addr;
      base_d = ld_addr;
      cnt_d  = '0;
    end else if (wr_en) begin
      ptr_d = ptr_q + 1'b1;
      if (cnt_q != LEN_MAX) begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (ptr_en) begin
      ptr_q  <= ptr_d;
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  p_len_cap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LEN_MAX);

  p_ld_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ld_set |=> (cnt_q == '0));

endmodule

// File: rtl/wp_rate_gen.sv
module wp_rate_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic             clear,
  input  logic [DIV_W-1:0] divider,
  output logic             tick
);

  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = run & (cnt_q == div_q - 1'b1);

  always_comb begin
    div_d = div_q;
    if (start) begin
      div_d = (divider == '0) ? DIV_W'(1) : divider;
    end
  end

  always_comb begin
    if (start || !run || clear || tick) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= DIV_W'(1);
      cnt_q <= '0;
    end else begin
      div_q <= div_d;
      cnt_q <= cnt_d;
    end
  end

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < div_q));

  p_div_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    div_q != '0);

endmodule

// File: rtl/wp_sequencer.sv
module wp_sequencer
  import wp_pkg::*;
#(
  parameter int DEPTH   = 1024,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic              clear,
  input  logic              loop_mode,
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  len,
  input  logic              tick,
  output logic              start,
  output logic              busy,
  output logic [ADDR_W-1:0] rd_addr
);

  play_state_e       state_q, state_d;
  play_mode_e        mode_q, mode_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W-1:0] first_q, first_d;
  logic [ADDR_W-1:0] last_q, last_d;

  assign busy    = (state_q == ST_RUN);
  assign rd_addr = addr_q;
  assign start   = ~busy & trig & ~clear & (len != '0);

  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    addr_d  = addr_q;
    first_d = first_q;
    last_d  = last_q;
    if (clear) begin
      state_d = ST_IDLE;
      addr_d  = '0;
    end else if (start) begin
      state_d = ST_RUN;
      mode_d  = loop_mode ? MODE_LOOP : MODE_ONCE;
      addr_d  = base;
      first_d = base;
      last_d  = base + len[ADDR_W-1:0] - 1'b1;
    end else if (busy && tick) begin
      if (addr_q == last_q) begin
        if (mode_q == MODE_LOOP) begin
          addr_d = first_q;
        end else begin
          state_d = ST_IDLE;
          addr_d  = '0;
        end
      end else begin
        addr_d = addr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_ONCE;
      addr_q  <= '0;
      first_q <= '0;
      last_q  <= '0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      addr_q  <= addr_d;
      first_q <= first_d;
      last_q  <= last_d;
    end
  end

  p_hold_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick && !clear) |=> $stable(addr_q));

  p_trig_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && trig && !clear && len != '0) |=> busy);

  p_idle_addr0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (addr_q == '0));

  p_retrig_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && trig && !clear && !tick) |=> (busy && $stable(addr_q)));

  p_clear_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !busy);

  p_empty_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && len == '0) |=> !busy);

  p_loop_stays_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_q == MODE_LOOP && !clear) |=> busy);

endmodule

// File: rtl/wave_player.sv
module wave_player #(
  parameter int SAMPLE_W = 14,
  parameter int DEPTH    = 1024,
  parameter int DIV_W    = 16,
  localparam int ADDR_W  = $clog2(DEPTH),
  localparam int CNT_W   = ADDR_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ld_set,
  input  logic [ADDR_W-1:0]   ld_addr,
  input  logic                wr_en,
  input  logic [SAMPLE_W-1:0] wr_data,
  input  logic [DIV_W-1:0]    divider,
  input  logic                loop_mode,
  input  logic                trig,
  input  logic                clear,
  output logic [SAMPLE_W-1:0] dac_out,
  output logic [SAMPLE_W-1:0] dac_out_n,
  output logic                busy
);

  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [ADDR_W-1:0] base;
  logic [CNT_W-1:0]  len;
  logic              tick;
  logic              start;
  logic [ADDR_W-1:0] rd_addr;
  logic [SAMPLE_W-1:0] rdata;

  wp_loader #(.DEPTH(DEPTH)) u_loader (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_set    (ld_set),
    .ld_addr   (ld_addr),
    .wr_en     (wr_en),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .base      (base),
    .len       (len)
  );

  wp_sample_ram #(.SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (wr_data),
    .raddr (rd_addr),
    .rdata (rdata)
  );

  wp_rate_gen #(.DIV_W(DIV_W)) u_rate (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .run     (busy),
    .clear   (clear),
    .divider (divider),
    .tick    (tick)
  );

  wp_sequencer #(.DEPTH(DEPTH)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig      (trig),
    .clear     (clear),
    .loop_mode (loop_mode),
    .base      (base),
    .len       (len),
    .tick      (tick),
    .start     (start),
    .busy      (busy),
    .rd_addr   (rd_addr)
  );

  assign dac_out   = rdata;
  assign dac_out_n = ~rdata;

  p_reset_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !busy);

endmodule

// File: tb/wave_player_bench.sv
module wave_player_bench;

  localparam int SW    = 14;
  localparam int DEP   = 16;
  localparam int DW    = 4;
  localparam int AW    = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ld_set;
  logic [AW-1:0] ld_addr;
  logic          wr_en;
  logic [SW-1:0] wr_data;
  logic [DW-1:0] divider;
  logic          loop_mode;
  logic          trig;
  logic          clear;
  logic [SW-1:0] dac_out;
  logic [SW-1:0] dac_out_n;
  logic          busy;

  int n_chk = 0;
  int n_bad = 0;
  int mem_m [DEP];
  int ptr_m = 0;
  int len_m = 0;
  int base_m = 0;

  always #10 clk = ~clk;

  wave_player #(.SAMPLE_W(SW), .DEPTH(DEP), .DIV_W(DW)) u_wave_player (
    .clk(clk), .rst_n(rst_n), .ld_set(ld_set), .ld_addr(ld_addr),
    .wr_en(wr_en), .wr_data(wr_data), .divider(divider),
    .loop_mode(loop_mode), .trig(trig), .clear(clear),
    .dac_out(dac_out), .dac_out_n(dac_out_n), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_base(input int a);
    @(negedge clk);
    ld_set = 1'b1; ld_addr = AW'(a);
    @(negedge clk);
    ld_set = 1'b0;
    ptr_m = a; base_m = a; len_m = 0;
  endtask

  task automatic push(input int v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = SW'(v);
    @(negedge clk);
    wr_en = 1'b0;
    mem_m[ptr_m] = v & 16'h3fff;
    ptr_m = (ptr_m + 1) % DEP;
    if (len_m < DEP) len_m++;
  endtask

  // Trigger, then compare each cycle against the arithmetic model.
  task automatic play(input int d_raw, input bit lp, input int cycles, input int retrig_j);
    int d = (d_raw == 0) ? 1 : d_raw;
    int total = len_m * d;
    @(negedge clk);
    divider = DW'(d_raw); loop_mode = lp; trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    for (int j = 0; j < cycles; j++) begin
      bit  eb = lp ? 1'b1 : (j < total);
      chk(busy == eb, lp ? "R5 busy" : "R4 busy", busy, eb);
      if (j >= 1) begin
        int m = j - 1;
        int ev;
        if (lp) ev = mem_m[(base_m + (m / d) % len_m) % DEP];
        else if (m < total) ev = mem_m[(base_m + m / d) % DEP];
        else ev = mem_m[0];
        chk(dac_out == SW'(ev), lp ? "R5 sample" : "R2 sample", dac_out, ev);
        chk(dac_out_n == ~dac_out, "R9 inverted", dac_out_n, ~dac_out);
      end
      if (j == retrig_j) trig = 1'b1;
      @(negedge clk);
      trig = 1'b0;
    end
  endtask

  task automatic stop_run();
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    chk(busy == 1'b0, "R8 busy", busy, 0);
    @(negedge clk);
    chk(dac_out == SW'(mem_m[0]), "R8 idle code", dac_out, mem_m[0]);
  endtask

  initial begin
    rst_n = 1'b0; ld_set = 1'b0; ld_addr = '0; wr_en = 1'b0; wr_data = '0;
    divider = '0; loop_mode = 1'b0; trig = 1'b0; clear = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R12 reset busy", busy, 0);

    // R10: nothing loaded yet, trigger ignored
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    chk(busy == 1'b0, "R10 empty trigger", busy, 0);

    // idle code at address 0
    set_base(0);
    push(14'h2a5);
    repeat (2) @(negedge clk);
    chk(dac_out == 14'h2a5, "R6 idle code", dac_out, 14'h2a5);

    // R1 R2 R3 R4 R7: sweep lengths and dividers in one-shot mode
    for (int l = 1; l <= 5; l++) begin
      for (int dv = 0; dv <= 4; dv++) begin
        set_base(2 + l);
        for (int k = 0; k < l; k++) push(16'h1000 + l * 256 + dv * 16 + k * 3 + 1);
        play(dv, 1'b0, l * ((dv == 0) ? 1 : dv) + 3, (l >= 2) ? 1 : -1);
        chk(dac_out == SW'(mem_m[0]), "R6 return to addr0", dac_out, mem_m[0]);
      end
    end

    // R5: loop mode over several periods, retrigger, then clear (R8)
    set_base(9);
    for (int k = 0; k < 3; k++) push(16'h3000 + k * 7);
    play(2, 1'b1, 20, 4);
    stop_run();

    // R8: clear in mid one-shot
    set_base(4);
    for (int k = 0; k < 4; k++) push(16'h0a00 + k);
    play(3, 1'b0, 3, -1);
    stop_run();

    // R10: base strobe without data leaves an empty table
    set_base(7);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    for (int j = 0; j < 3; j++) begin
      chk(busy == 1'b0, "R10 empty busy", busy, 0);
      @(negedge clk);
    end

    // R11: table wrapping across address 0
    set_base(14);
    for (int k = 0; k < 4; k++) push(16'h2200 + k);
    play(1, 1'b0, 7, -1);

    // R11: over-full table, length saturates at depth
    set_base(5);
    for (int k = 0; k < 20; k++) push(16'h1500 + k * 5);
    chk(len_m == DEP, "R11 model length", len_m, DEP);
    play(1, 1'b0, DEP + 3, -1);
    play(0, 1'b0, DEP + 3, 3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule